// File: doc/BRIEF.md
# Clock Modulation Duty Controller

This block produces one clock-enable line per core. The lines follow a repeating 16-cycle pattern, and downstream gating logic uses them to cut dynamic power by clock modulation. Each core has a 5-bit control word written by software. The word holds an enable bit and a duty field. A shared legacy control path can impose one duty on every core at once. A thermal-engage input can impose a fixed, factory-chosen duty on every core, overriding both software paths.

For each core, a combinational arbiter picks the winning duty source. A small per-core state machine captures that choice only on the last cycle of each frame. An accumulator then spreads the asserted cycles evenly across the next frame. A single frame timer is shared by all cores, so the frames of all cores line up.

Each per-core machine has two states. `ST_FULL` holds the enable high. `ST_MOD` outputs the spread pattern. There are four transitions, all taken at the frame-end cycle:
- `T_ENGAGE` (`ST_FULL` to `ST_MOD`) when the captured duty is nonzero.
- `T_RELEASE` (`ST_MOD` to `ST_FULL`) when the captured duty is zero.
- `T_RELOAD` (`ST_MOD` to `ST_MOD`) when a new nonzero duty is captured.
- `T_HOLD` (`ST_FULL` to `ST_FULL`) when the duty stays zero.

Top module: `cm_clkmod_ctrl`

## Requirements
- R1: While reset is low, every `clk_en` bit is 1. The first cycle after reset release is frame position 0, and that whole first frame keeps `clk_en` at 1 whatever the inputs are.
- R2: Per-core word layout: bit 4 is the enable bit and bits 3:1 give the duty in eighths. With `FINE_STEP`=1, bits 3:0 together give the duty N in sixteenths.
- R3: With `FINE_STEP`=0, bit 0 of every duty field is ignored, and N = 2 × bits 3:1.
- R4: When neither override is active, each core follows only its own control word.
- R5: While `legacy_en` is 1, the duty `legacy_duty` applies to all cores, whatever their enable bits are. It uses the same 4-bit field format as the per-core word.
- R6: When the legacy duty and a core's own enabled setting conflict, the legacy duty wins.
- R7: While `tcc_engage` is 1, every core uses N = `TCC_SIXTEENTHS`. This overrides both the legacy setting and the per-core settings.
- R8: A core holds `clk_en` at 1 in two cases: when its selected N is 0 (a zero field, or no active source), and when it is disabled with no override active.
- R9: Frames are 16 cycles long. At frame position p (0 to 15), `clk_en` is 1 exactly when floor((p+1)·N/16) > floor(p·N/16). This gives exactly N asserted cycles per frame.
- R10: Inputs are sampled only on the cycle at frame position 15. Changes made at other positions have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_ctrl | input | NUM_CORES*5 | Per-core control words; core k occupies bits 5k+4:5k |
| legacy_en | input | 1 | Legacy shared-duty control active |
| legacy_duty | input | 4 | Shared duty field, same format as the per-core word bits 3:0 |
| tcc_engage | input | 1 | Thermal control engaged; forces the factory duty |
| clk_en | output | NUM_CORES | Per-core clock enable pattern |

## Verification
Inputs take effect only through the capture on the frame-end cycle. The first pattern bit from a new setting therefore appears in the cycle after that edge and lasts exactly 16 cycles. `clk_en` is decoded directly from registers, so each frame-position value is valid for the whole cycle. The bench changes inputs on the falling edge inside position 15. It then compares `clk_en` on the falling edge of each of the next 16 cycles against the expected bit for that position. For mid-frame changes, the bench keeps expecting the old pattern until the boundary has passed.

// File: rtl/cm_pkg.sv
`timescale 1ns/1ps
package cm_pkg;
    localparam int FRAME_BITS = 4;
    localparam int FRAME_LEN  = 1 << FRAME_BITS;
    localparam int FIELD_W    = 4;
    localparam int CTRL_W     = FIELD_W + 1;

    // duty in sixteenths, 0..16
    typedef logic [FRAME_BITS:0] duty_t;

    typedef struct packed {
        logic               enable;
        logic [FIELD_W-1:0] field;
    } core_ctrl_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CORE,
        SRC_LEGACY,
        SRC_THERMAL
    } duty_src_e;

    typedef enum logic {
        ST_FULL,
        ST_MOD
    } mod_state_e;
endpackage

// File: rtl/cm_frame_timer.sv
`timescale 1ns/1ps
module cm_frame_timer
    import cm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [FRAME_BITS-1:0] pos,
    output logic                  frame_last
);
    localparam logic [FRAME_BITS-1:0] LAST_POS = FRAME_BITS'(FRAME_LEN - 1);

    logic [FRAME_BITS-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_q + 1'b1;
    end

    assign pos        = pos_q;
    assign frame_last = (pos_q == LAST_POS);

    assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> (pos == '0));
    assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> (pos == $past(pos) + 1'b1));
endmodule

// File: rtl/cm_source_arbiter.sv
`timescale 1ns/1ps
module cm_source_arbiter
    import cm_pkg::*;
#(
    parameter bit FINE_STEP      = 1'b1,
    parameter int TCC_SIXTEENTHS = 6
) (
    input  core_ctrl_t         ctrl,
    input  logic               legacy_en,
    input  logic [FIELD_W-1:0] legacy_field,
    input  logic               tcc_engage,
    output duty_t              sel_n
);
    localparam duty_t TCC_N = duty_t'(TCC_SIXTEENTHS);

    function automatic duty_t field_to_n(input logic [FIELD_W-1:0] f);
        if (FINE_STEP) return {1'b0, f};
        else           return {1'b0, f[FIELD_W-1:1], 1'b0};
    endfunction

    duty_src_e src;

    always_comb begin
        if (tcc_engage)       src = SRC_THERMAL;
        else if (legacy_en)   src = SRC_LEGACY;
        else if (ctrl.enable) src = SRC_CORE;
        else                  src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_THERMAL: sel_n = TCC_N;
            SRC_LEGACY:  sel_n = field_to_n(legacy_field);
            SRC_CORE:    sel_n = field_to_n(ctrl.field);
            default:     sel_n = '0;
        endcase
    end

    always_comb begin
        if (tcc_engage) assert_thermal_wins_R7: assert (sel_n == TCC_N);
    end
endmodule

// File: rtl/cm_duty_gen.sv
`timescale 1ns/1ps
module cm_duty_gen
    import cm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_last,
    input  duty_t sel_n,
    output duty_t act_n,
    output logic  clk_en
);
    mod_state_e            state_q, state_d;
    duty_t                 act_q;
    logic [FRAME_BITS-1:0] acc_q;
    logic [FRAME_BITS+1:0] sum;
    logic                  carry;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FULL;
        else        state_q <= state_d;
    end

    // transitions: T_ENGAGE, T_RELEASE, T_RELOAD, T_HOLD at frame end only
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL: if (frame_last && sel_n != '0) state_d = ST_MOD;
            ST_MOD:  if (frame_last && sel_n == '0) state_d = ST_FULL;
            default: state_d = ST_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            acc_q <= '0;
        end else if (frame_last) begin
            act_q <= sel_n;
            acc_q <= '0;
        end else begin
            acc_q <= sum[FRAME_BITS-1:0];
        end
    end

    assign sum   = {2'b00, acc_q} + {1'b0, act_q};
    assign carry = |sum[FRAME_BITS+1:FRAME_BITS];

    // outputs
    always_comb begin
        unique case (state_q)
            ST_FULL: clk_en = 1'b1;
            ST_MOD:  clk_en = carry;
            default: clk_en = 1'b1;
        endcase
    end

    assign act_n = act_q;

    // per-frame count checker
    logic [FRAME_BITS:0]   en_cnt;
    logic [FRAME_BITS+1:0] want_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_last) en_cnt <= '0;
        else                      en_cnt <= en_cnt + {{FRAME_BITS{1'b0}}, clk_en};
    end

    assign want_cnt = (state_q == ST_FULL) ? (FRAME_BITS+2)'(FRAME_LEN) : {1'b0, act_q};

    assert_frame_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> ({1'b0, en_cnt} + {{(FRAME_BITS+1){1'b0}}, clk_en}) == want_cnt);
    assert_hold_midframe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> $stable(act_n));
    assert_zero_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && sel_n == '0) |=> clk_en);
endmodule

// File: rtl/cm_clkmod_ctrl.sv
`timescale 1ns/1ps
module cm_clkmod_ctrl
    import cm_pkg::*;
#(
    parameter int NUM_CORES      = 4,
    parameter bit FINE_STEP      = 1'b1,
    parameter int TCC_SIXTEENTHS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES*CTRL_W-1:0] core_ctrl,
    input  logic                        legacy_en,
    input  logic [FIELD_W-1:0]          legacy_duty,
    input  logic                        tcc_engage,
    output logic [NUM_CORES-1:0]        clk_en
);
    localparam duty_t TCC_N = duty_t'(TCC_SIXTEENTHS);

    logic [FRAME_BITS-1:0] pos;
    logic                  frame_last;
    duty_t                 sel_n [NUM_CORES];
    duty_t                 act_n [NUM_CORES];

    cm_frame_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos        (pos),
        .frame_last (frame_last)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        core_ctrl_t ctrl;
        assign ctrl = core_ctrl[g*CTRL_W +: CTRL_W];

        cm_source_arbiter #(
            .FINE_STEP      (FINE_STEP),
            .TCC_SIXTEENTHS (TCC_SIXTEENTHS)
        ) u_arb (
            .ctrl         (ctrl),
            .legacy_en    (legacy_en),
            .legacy_field (legacy_duty),
            .tcc_engage   (tcc_engage),
            .sel_n        (sel_n[g])
        );

        cm_duty_gen u_gen (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_last (frame_last),
            .sel_n      (sel_n[g]),
            .act_n      (act_n[g]),
            .clk_en     (clk_en[g])
        );

        assert_thermal_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_last && tcc_engage) |=> (act_n[g] == TCC_N));
        assert_legacy_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_last && legacy_en && !tcc_engage) |=> (act_n[g] == act_n[0]));
    end

    assert_reset_high_R1: assert property (@(posedge clk)
        !rst_n |=> (&clk_en));
endmodule

// File: tb/tb_cm_clkmod_ctrl.sv
`timescale 1ns/1ps
module tb_cm_clkmod_ctrl;
    localparam int NC   = 4;
    localparam int TCCN = 6;
    localparam int NV   = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC*5-1:0] core_ctrl;
    logic          legacy_en;
    logic [3:0]    legacy_duty;
    logic          tcc_engage;
    logic [NC-1:0] en_f, en_c;

    always #2 clk = ~clk;

    cm_clkmod_ctrl #(.NUM_CORES(NC), .FINE_STEP(1'b1), .TCC_SIXTEENTHS(TCCN)) dut (
        .clk(clk), .rst_n(rst_n), .core_ctrl(core_ctrl), .legacy_en(legacy_en),
        .legacy_duty(legacy_duty), .tcc_engage(tcc_engage), .clk_en(en_f));
    cm_clkmod_ctrl #(.NUM_CORES(NC), .FINE_STEP(1'b0), .TCC_SIXTEENTHS(TCCN)) dut_c (
        .clk(clk), .rst_n(rst_n), .core_ctrl(core_ctrl), .legacy_en(legacy_en),
        .legacy_duty(legacy_duty), .tcc_engage(tcc_engage), .clk_en(en_c));

    // {core3, core2, core1, core0, legacy_en, legacy_duty, tcc}
    localparam logic [25:0] VEC [NV] = '{
        {5'b10000, 5'b01111, 5'b10011, 5'b11000, 1'b0, 4'h0, 1'b0},
        {5'b10101, 5'b10110, 5'b10001, 5'b11111, 1'b0, 4'h0, 1'b0},
        {5'b11000, 5'b11001, 5'b10110, 5'b10111, 1'b0, 4'h0, 1'b0},
        {5'b10000, 5'b01111, 5'b10011, 5'b11000, 1'b1, 4'h5, 1'b0},
        {5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b1, 4'hA, 1'b0},
        {5'b10101, 5'b10110, 5'b10001, 5'b11111, 1'b1, 4'h3, 1'b1},
        {5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b0, 4'h0, 1'b1},
        {5'b10101, 5'b10110, 5'b10001, 5'b11111, 1'b1, 4'h0, 1'b0},
        {5'b10001, 5'b00001, 5'b01000, 5'b10000, 1'b0, 4'h0, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R4";
            1: return "R2";
            2: return "R3";
            3: return "R6";
            4: return "R5";
            5, 6: return "R7";
            default: return "R8";
        endcase
    endfunction

    int n_cmp = 0;
    int n_bad = 0;
    int exp_f [NC];
    int exp_c [NC];
    logic [25:0] mid_vec;

    function automatic int model_n(input logic [4:0] c, input logic le, input logic [3:0] ld,
                                   input logic tc, input bit fine);
        logic [3:0] f;
        if (tc) return TCCN;
        if (!le && !c[4]) return 0;
        f = le ? ld : c[3:0];
        return fine ? int'(f) : 2 * int'(f[3:1]);
    endfunction

    function automatic logic bit_at(input int n, input int p);
        if (n == 0) return 1'b1;
        return (((p + 1) * n) / 16) > ((p * n) / 16);
    endfunction

    task automatic apply(input logic [25:0] v);
        core_ctrl   = v[25:6];
        legacy_en   = v[5];
        legacy_duty = v[4:1];
        tcc_engage  = v[0];
    endtask

    task automatic latch_exp();
        for (int c = 0; c < NC; c++) begin
            exp_f[c] = model_n(core_ctrl[c*5 +: 5], legacy_en, legacy_duty, tcc_engage, 1'b1);
            exp_c[c] = model_n(core_ctrl[c*5 +: 5], legacy_en, legacy_duty, tcc_engage, 1'b0);
        end
    endtask

    task automatic check_cycle(input int p, input string req);
        logic [NC-1:0] wf, wc;
        for (int c = 0; c < NC; c++) begin
            wf[c] = bit_at(exp_f[c], p);
            wc[c] = bit_at(exp_c[c], p);
        end
        n_cmp += 2;
        if (en_f !== wf) begin
            n_bad++;
            $display("FAIL %s fine pos %0d: clk_en=%b expected %b", req, p, en_f, wf);
        end
        if (en_c !== wc) begin
            n_bad++;
            $display("FAIL %s coarse pos %0d: clk_en=%b expected %b", req, p, en_c, wc);
        end
    endtask

    // starts at falling edge inside position 15, ends at the same point one frame later
    task automatic run_frame(input string req, input bit mid);
        for (int p = 0; p < 16; p++) begin
            @(posedge clk);
            @(negedge clk);
            check_cycle(p, req);
            if (mid && p == 7) apply(mid_vec);
        end
    endtask

    // reset, then one full frame expected at all-high (R1)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int c = 0; c < NC; c++) begin exp_f[c] = 0; exp_c[c] = 0; end
        @(negedge clk);
        @(negedge clk);
        check_cycle(0, "R1");
        rst_n = 1'b1;
        #1 check_cycle(0, "R1");
        for (int p = 1; p < 16; p++) begin
            @(posedge clk);
            @(negedge clk);
            check_cycle(p, "R1");
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        apply('0);
        repeat (3) @(posedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            latch_exp();
            run_frame(vec_tag(i), 1'b0);
        end

        // R10: change mid frame, old pattern must finish the frame
        apply(VEC[0]);
        latch_exp();
        mid_vec = VEC[1];
        run_frame("R10", 1'b1);
        latch_exp();
        run_frame("R10", 1'b0);

        // R10: brief thermal pulse away from frame end has no effect
        latch_exp();
        mid_vec = VEC[1];
        mid_vec[0] = 1'b1;
        run_frame("R10", 1'b1);
        apply(VEC[1]);
        latch_exp();
        run_frame("R10", 1'b0);

        // R1: reset during modulation with inputs still active
        apply(VEC[1]);
        do_reset();
        latch_exp();
        run_frame("R9", 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule